// File: doc/BRIEF.md
# Real-Time Clock with Alarm Wake-Up Interrupt

This block keeps the time of day as hours, minutes and seconds in BCD, advanced by a one-second tick that a prescaler derives from a slow reference clock (32768 Hz by default). A host reads and writes the time, the three alarm fields and a small control register through a parallel register port. The host uses it to wake itself after a chosen time.

Before the host goes to sleep it loads the wake-up time into the alarm fields and raises a power-down input. While power-down is high the active-low interrupt line stays released unless an alarm is pending. When the running time steps onto the alarm time, a pending flag is set and the line is pulled low. The line is pulled low even while power-down is still high, so the sleeping host can be reset and woken by it. Once running again, the host clears the pending flag with a write to the control register.

The interrupt pin is presented as a drive enable plus a data bit that is always zero, so a pad or the chip top can build the open-drain style output from them.

Top module: `rtc_wake_ctrl`

## Requirements
- R1: After reset, every readable register (addresses 0 to 7) reads 0x00 and `irq_oe` is 0.
- R2: With no write to a time register, the seconds field advances by one every PRESCALE_DIV clock cycles.
- R3: The counters use BCD. Seconds wrap from 0x59 to 0x00 and carry into minutes. Minutes wrap from 0x59 to 0x00 and carry into hours. Hours wrap from 0x23 to 0x00, so 23:59:59 becomes 00:00:00.
- R4: Register map on `addr`: 0 seconds, 1 minutes, 2 hours, 3 alarm seconds, 4 alarm minutes, 5 alarm hours, 6 control. A write stores `wdata` and `rdata` shows the addressed value combinationally. Address 7 reads 0x00 and a write to it changes nothing.
- R5: A write to any time register (addresses 0 to 2) restarts the prescaler. The next advance of the seconds field happens exactly PRESCALE_DIV cycles after the write edge.
- R6: A tick that moves the time onto a value equal to all three alarm fields sets the pending flag on that same edge. The flag is set only once for each such match.
- R7: The pending flag stays set until a control write with bit 0 = 1. A control write with bit 0 = 0 leaves the flag unchanged. A new match wins over a clear in the same cycle.
- R8: `irq_oe` is 1 exactly when the flag is pending and either `pwr_dn` is 1 or the alarm enable (control bit 1) is 1. `irq_data` is always 0.
- R9: While `pwr_dn` is 1 and nothing is pending, the interrupt line is released. While `pwr_dn` is 1 and an alarm is pending, the line is driven regardless of the alarm enable.
- R10: Reading the control register returns bit 0 = pending flag, bit 1 = alarm enable, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (one cycle of the slow time base) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pwr_dn | input | 1 | Host power-down request |
| irq_oe | output | 1 | Drive enable of the active-low interrupt line |
| irq_data | output | 1 | Data of the interrupt line, always 0 |

## Verification
The checks assume that the host writes only valid BCD values to the time and alarm fields: seconds and minutes at most 0x59, hours at most 0x23. An out-of-range value would make the counters step through codes outside the ranges that the rollover rules describe. The assertions also assume that PRESCALE_DIV is at least 2, so two ticks never fall on consecutive cycles. The random stimulus builds every time and alarm value from an integer within its range, converted to BCD. It writes arbitrary bytes only to the control register and to the unused address 7. The prescaler is shortened in the bench so that many seconds, rollovers and alarm matches fit in the run.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;

  localparam int unsigned FIELD_W = 8;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NFIELDS = 3;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] A_ASEC = 3'd3;
  localparam logic [ADDR_W-1:0] A_AMIN = 3'd4;
  localparam logic [ADDR_W-1:0] A_AHR  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd6;

  localparam logic [FIELD_W-1:0] SEXA_TOP = 8'h59;
  localparam logic [FIELD_W-1:0] HOUR_TOP = 8'h23;

  // Upper bound of field g: seconds and minutes end at 59, hours at 23
  function automatic logic [FIELD_W-1:0] field_top(input int g);
    return (g == 2) ? HOUR_TOP : SEXA_TOP;
  endfunction

  // One BCD step: result[8] is the carry out, result[7:0] the next value
  function automatic logic [FIELD_W:0] bcd_step(input logic [FIELD_W-1:0] v,
                                                 input logic [FIELD_W-1:0] top);
    logic [3:0] hi;
    logic [3:0] lo;
    hi = v[7:4];
    lo = v[3:0];
    if (v == top)        return {1'b1, 8'h00};
    else if (lo == 4'd9) return {1'b0, hi + 4'd1, 4'd0};
    else                 return {1'b0, hi, lo + 4'd1};
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart_i,
  output logic                       tick_o,
  output logic [$clog2(DIV)-1:0]     cnt_o
);
  localparam int unsigned CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  // a time write in the final cycle swallows that tick
  assign tick_o  = at_last && !restart_i;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (restart_i || at_last) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_wake_pkg::*;
#(
  parameter logic [FIELD_W-1:0] TOP = 8'h59
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  input  logic               wr_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [FIELD_W-1:0] q_o,
  output logic [FIELD_W-1:0] nxt_o,
  output logic               carry_o
);
  logic [FIELD_W-1:0] q;
  logic [FIELD_W:0]   step;

  assign step    = bcd_step(q, TOP);
  assign nxt_o   = inc_i ? step[FIELD_W-1:0] : q;
  assign carry_o = inc_i && step[FIELD_W];
  assign q_o     = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (wr_i) q <= wdata_i;
    else           q <= nxt_o;
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic ctrl_wr_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic pwr_dn_i,
  output logic pending_o,
  output logic alarm_en_o,
  output logic oe_o
);
  logic pend_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (match_i)                 pend_q <= 1'b1;
      else if (ctrl_wr_i && clr_i) pend_q <= 1'b0;
      if (ctrl_wr_i)               en_q   <= en_i;
    end
  end

  assign pending_o  = pend_q;
  assign alarm_en_o = en_q;
  assign oe_o       = pend_q && (pwr_dn_i || en_q);
endmodule

// File: rtl/rtc_wake_ctrl.sv
module rtc_wake_ctrl
  import rtc_wake_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              pwr_dn,
  output logic              irq_oe,
  output logic              irq_data
);
  localparam int unsigned CW = $clog2(PRESCALE_DIV);

  // named internal events, also observed by the checker
  logic          time_wr;
  logic          ctrl_wr;
  logic          tick;
  logic          alarm_hit;
  logic          pending;
  logic          alarm_en;
  logic          presc_at_zero;
  logic [CW-1:0] presc_cnt;

  logic [NFIELDS:0]   inc_chain;
  logic [FIELD_W-1:0] tq   [NFIELDS];
  logic [FIELD_W-1:0] tn   [NFIELDS];
  logic [FIELD_W-1:0] alm  [NFIELDS];
  logic [NFIELDS-1:0] fld_eq;

  assign time_wr       = wr_en && (addr <= A_HOUR);
  assign ctrl_wr       = wr_en && (addr == A_CTRL);
  assign presc_at_zero = (presc_cnt == '0);

  rtc_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(time_wr),
    .tick_o   (tick),
    .cnt_o    (presc_cnt)
  );

  assign inc_chain[0] = tick;

  for (genvar g = 0; g < NFIELDS; g++) begin : g_time
    rtc_bcd_field #(.TOP(field_top(g))) u_fld (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (inc_chain[g]),
      .wr_i   (wr_en && (addr == ADDR_W'(g))),
      .wdata_i(wdata),
      .q_o    (tq[g]),
      .nxt_o  (tn[g]),
      .carry_o(inc_chain[g+1])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      alm[g] <= '0;
      else if (wr_en && (addr == ADDR_W'(g + NFIELDS))) alm[g] <= wdata;
    end

    assign fld_eq[g] = (tn[g] == alm[g]);
  end

  // compare the value the tick is about to load, so a match is seen once
  assign alarm_hit = tick && (&fld_eq);

  rtc_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_i   (alarm_hit),
    .ctrl_wr_i (ctrl_wr),
    .clr_i     (wdata[0]),
    .en_i      (wdata[1]),
    .pwr_dn_i  (pwr_dn),
    .pending_o (pending),
    .alarm_en_o(alarm_en),
    .oe_o      (irq_oe)
  );

  assign irq_data = 1'b0;

  always_comb begin
    case (addr)
      A_SEC:   rdata = tq[0];
      A_MIN:   rdata = tq[1];
      A_HOUR:  rdata = tq[2];
      A_ASEC:  rdata = alm[0];
      A_AMIN:  rdata = alm[1];
      A_AHR:   rdata = alm[2];
      A_CTRL:  rdata = {6'b0, alarm_en, pending};
      default: rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/rtc_wake_chk.sv
module rtc_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       time_wr,
  input logic       ctrl_wr,
  input logic       clr_bit,
  input logic       alarm_hit,
  input logic       pending,
  input logic       pwr_dn,
  input logic       irq_oe,
  input logic       presc_at_zero,
  input logic [7:0] sec
);
  AST_OE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> pending);  // R8
  AST_OE_IN_POWERDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && pwr_dn) |-> irq_oe);  // R9
  AST_HIT_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> pending);  // R6
  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> !alarm_hit);  // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && clr_bit && !alarm_hit) |=> !pending);  // R7
  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !(ctrl_wr && clr_bit)) |=> pending);  // R7
  AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> presc_at_zero);  // R5
  AST_SEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !time_wr) |=> $stable(sec));  // R2
endmodule

bind rtc_wake_ctrl rtc_wake_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .time_wr      (time_wr),
  .ctrl_wr      (ctrl_wr),
  .clr_bit      (wdata[0]),
  .alarm_hit    (alarm_hit),
  .pending      (pending),
  .pwr_dn       (pwr_dn),
  .irq_oe       (irq_oe),
  .presc_at_zero(presc_at_zero),
  .sec          (tq[0])
);

// File: tb/sim_rtc_wake_ctrl.sv
module sim_rtc_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwr_dn = 1'b0;
  logic       irq_oe;
  logic       irq_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_wake_ctrl #(.PRESCALE_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwr_dn(pwr_dn), .irq_oe(irq_oe), .irq_data(irq_data)
  );

  // ---------------- bench arithmetic ----------------
  function automatic int bcd2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  // whole-day seconds count, plus one, wrapped
  function automatic logic [23:0] day_next(input logic [23:0] hms);
    int s;
    s = bcd2i(hms[7:0]) + 60 * bcd2i(hms[15:8]) + 3600 * bcd2i(hms[23:16]);
    s = (s + 1) % 86400;
    return {i2bcd(s / 3600), i2bcd((s / 60) % 60), i2bcd(s % 60)};
  endfunction

  // ---------------- reference model ----------------
  logic [7:0] m_t [3];
  logic [7:0] m_a [3];
  int         m_cnt;
  bit         m_pend, m_en;

  always @(posedge clk or negedge rst_n) begin : mdl
    bit twr, tk, hit;
    logic [23:0] adv;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_t[i] = 0; m_a[i] = 0; end
      m_cnt = 0; m_pend = 0; m_en = 0;
    end else begin
      twr = wr_en && (addr <= 3'd2);
      tk  = (m_cnt == DIV - 1) && !twr;
      m_cnt = (twr || m_cnt == DIV - 1) ? 0 : m_cnt + 1;
      adv = day_next({m_t[2], m_t[1], m_t[0]});
      hit = tk && (adv == {m_a[2], m_a[1], m_a[0]});
      if (tk) begin m_t[2] = adv[23:16]; m_t[1] = adv[15:8]; m_t[0] = adv[7:0]; end
      if (wr_en) begin
        case (addr)
          3'd0, 3'd1, 3'd2: m_t[addr] = wdata;
          3'd3, 3'd4, 3'd5: m_a[addr - 3'd3] = wdata;
          3'd6: begin
            m_en = wdata[1];
            if (wdata[0]) m_pend = 0;
          end
          default: ;
        endcase
      end
      if (hit) m_pend = 1;
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2: return m_t[a];
      3'd3, 3'd4, 3'd5: return m_a[a - 3'd3];
      3'd6: return {6'b0, m_en, m_pend};
      default: return 8'h00;
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R4 rdata vs model", rdata, m_read(addr));
    chk("R8 irq_oe vs model", irq_oe, m_pend && (pwr_dn || m_en));
    chk("R8 irq_data", irq_data, 0);
  endtask

  // wait for the negedge, compare, then apply the next inputs
  task automatic cyc(input bit w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cmp_model();
    wr_en = w; addr = a; wdata = d;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
    cyc(0, a, 8'h00);
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    int got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 0, "R1 reset read");
    chk("R1 irq_oe after reset", irq_oe, 0);

    // R5 / R2: write restarts prescaler, next advance DIV cycles later
    cyc(1, 3'd0, 8'h10);
    for (int m = 0; m < DIV; m++) rd_chk(3'd0, 8'h10, "R5 no advance before full period");
    rd_chk(3'd0, 8'h11, "R2 advance after full period");

    // R4: alarm away from midnight
    cyc(1, 3'd5, 8'h12);
    rd_chk(3'd5, 8'h12, "R4 alarm hours readback");
    cyc(1, 3'd7, 8'hA5);
    rd_chk(3'd7, 8'h00, "R4 address 7 reads zero");
    rd_chk(3'd5, 8'h12, "R4 address 7 write has no effect");

    // R3: full-day rollover
    cyc(1, 3'd2, 8'h23);
    cyc(1, 3'd1, 8'h59);
    cyc(1, 3'd0, 8'h59);
    repeat (DIV + 1) cyc(0, 3'd0, 8'h00);
    rd_chk(3'd0, 8'h00, "R3 seconds wrap");
    rd_chk(3'd1, 8'h00, "R3 minutes wrap");
    rd_chk(3'd2, 8'h00, "R3 hours wrap");

    // R6 / R9: alarm at 00:00:03 while powered down, enable off
    cyc(1, 3'd5, 8'h00);
    cyc(1, 3'd3, 8'h03);
    cyc(1, 3'd6, 8'h00);
    pwr_dn = 1'b1;
    rd_chk(3'd6, 0, "R9 released in power-down while idle");
    chk("R9 irq_oe released", irq_oe, 0);
    got = 0;
    for (int k = 0; k < 8 * DIV && got == 0; k++) begin
      cyc(0, 3'd6, 8'h00);
      #1;
      if (rdata[0]) got = 1;
    end
    chk("R6 pending seen", got, 1);
    chk("R9 driven in power-down", irq_oe, 1);
    rd_chk(3'd0, 8'h03, "R6 time equals alarm at pending");
    rd_chk(3'd6, 8'h01, "R10 control readback pending only");

    // R8 / R7
    pwr_dn = 1'b0;
    #1 chk("R8 released without enable", irq_oe, 0);
    cyc(1, 3'd6, 8'h02);
    rd_chk(3'd6, 8'h03, "R7 bit0=0 keeps pending, R10 enable bit");
    chk("R8 driven with enable", irq_oe, 1);
    cyc(1, 3'd6, 8'h03);
    rd_chk(3'd6, 8'h02, "R7 bit0=1 clears pending");
    chk("R8 released after clear", irq_oe, 0);
    repeat (3 * DIV) cyc(0, 3'd6, 8'h00);
    #1 chk("R6 no second match", rdata[0], 0);

    // random phase, checked every cycle against the model
    for (int n = 0; n < 6000; n++) begin
      bit w;
      logic [2:0] a;
      logic [7:0] d;
      w = ($urandom % 6) == 0;
      a = 3'($urandom % 8);
      case (a)
        3'd0, 3'd1, 3'd3, 3'd4: d = i2bcd($urandom % 60);
        3'd2, 3'd5:             d = i2bcd($urandom % 24);
        3'd6:                   d = 8'($urandom % 4);
        default:                d = 8'($urandom);
      endcase
      if (($urandom % 40) == 0) pwr_dn = ~pwr_dn;
      if ((n % 150) == 0) begin
        // aim the alarm a few seconds ahead (R6)
        cyc(1, 3'd5, m_t[2]);
        cyc(1, 3'd4, m_t[1]);
        cyc(1, 3'd3, i2bcd((bcd2i(m_t[0]) + 2 + int'($urandom % 3)) % 60));
      end
      cyc(w, a, d);
    end
    cyc(0, 3'd0, 8'h00);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1879));
  end
endmodule